// File: doc/BRIEF.md
# Two-Tier Packet Quota Throttle

This block decides, request by request, whether a packet of one of four types may go on to a storage recorder. Each type has two byte budgets. The first is a running per-orbit budget that limits total storage use over an orbit. The second is a per-second budget that limits bursts. A granted packet's length is taken from both budgets. A type is blocked while either budget is empty. The per-second budget is refilled on every one-second tick.

At the end of each orbit, the block adds up the orbit budget every type left unused into a pool. Each type then gets its programmable baseline plus a programmable fraction of that pool. This lets busy sources use capacity that quiet sources gave up. The recompute runs in hardware over a fixed two-cycle window, and no grants are issued during that window. A reset-quota command, or a block reset, reloads every orbit budget with its baseline and every per-second budget with its limit.

Top module: `quota_throttle`

## Requirements
- R1: After reset, no request is pending, `busy` is low, and each type's orbit budget equals its baseline field (type i uses bits [16i+15:16i] of `baseAlloc`) and its per-second budget equals its `secLimit` field.
- R2: A request gets `grant` in the same cycle only if all of these hold: `reqValid` is high, the block is not busy, no orbit-end or reset-quota pulse is present, and both budgets of `reqType` are nonzero. `blocked` is high exactly when `reqValid` is high and `grant` is low.
- R3: A grant subtracts `reqLen` from that type's orbit budget. A length larger than the remainder is still granted, and the budget stops at zero instead of wrapping.
- R4: A type whose orbit budget is zero is refused until the next reload. Other types are not affected.
- R5: A grant also subtracts `reqLen` from the type's per-second budget, stopping at zero. A zero per-second budget refuses the type until the next tick.
- R6: A `secTick` in the same cycle as a request refills the per-second budget with `secLimit` first. The request is then judged against, and taken from, the refilled value.
- R7: `quotaReset` reloads all orbit budgets with the baselines and all per-second budgets with the limits, effective the next cycle. A request in the same cycle is refused, and a running reallocation is abandoned.
- R8: An `orbitEnd` pulse while idle raises `busy` for exactly two cycles. No grant is issued in the pulse cycle or while `busy` is high. An `orbitEnd` that arrives while busy is ignored.
- R9: After reallocation, type i's orbit budget is min(65535, base_i + floor(P·pct_i/256)). P is the sum of all four orbit budgets in the `orbitEnd` cycle, and pct_i is bits [8i+7:8i] of `sharePct`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Packet request present |
| reqType | input | 2 | Packet type of the request |
| reqLen | input | 12 | Packet length in bytes |
| secTick | input | 1 | One-second refill pulse |
| orbitEnd | input | 1 | End-of-orbit pulse, starts reallocation |
| quotaReset | input | 1 | Reload all budgets from their settings |
| baseAlloc | input | 64 | Per-type orbit baseline, 16 bits each |
| secLimit | input | 64 | Per-type per-second limit, 16 bits each |
| sharePct | input | 32 | Per-type pool share in 1/256 units, 8 bits each |
| grant | output | 1 | Request accepted this cycle |
| blocked | output | 1 | Request refused this cycle |
| busy | output | 1 | Reallocation in progress |

## Verification
A wrong budget value is visible at the ports only through the grant pattern. An off-by-one remainder shows up as an extra or missing grant on the last single-byte request before a type runs dry. The bench therefore drains every type in large chunks and then probes it byte by byte, comparing each grant with an arithmetic model. A wrong pool sum or share is seen on the first drain after `busy` falls. A wrong tick or reset-quota priority is seen in the very cycle of the pulse.

// File: rtl/qthr_pkg.sv
package qthr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SUM, ST_LOAD} qthr_state_t;

  typedef struct packed {
    logic takeGrant;
    logic capturePool;
    logic loadRealloc;
    logic loadBase;
  } qthr_strobe_t;
endpackage

// File: rtl/qthr_ctl.sv
module qthr_ctl
  import qthr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         typeOk,
  input  logic         orbitEnd,
  input  logic         quotaReset,
  output qthr_strobe_t strobe,
  output logic         grant,
  output logic         blocked,
  output logic         busy
);
  qthr_state_t state;
  logic inhibit;

  always_ff @(posedge clk) begin
    if (!rstN || quotaReset) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (orbitEnd) state <= ST_SUM;
        ST_SUM:  state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state != ST_IDLE);
    inhibit = busy || orbitEnd || quotaReset;
    grant   = reqValid && !inhibit && typeOk;
    blocked = reqValid && !grant;
    strobe.takeGrant   = grant;
    strobe.capturePool = (state == ST_SUM) && !quotaReset;
    strobe.loadRealloc = (state == ST_LOAD) && !quotaReset;
    strobe.loadBase    = quotaReset;
  end
endmodule

// File: rtl/qthr_dp.sv
module qthr_dp
  import qthr_pkg::*;
#(
  parameter int NT = 4,
  parameter int QW = 16,
  parameter int LW = 12,
  parameter int PW = 8,
  localparam int TW = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rstN,
  input  qthr_strobe_t   strobe,
  input  logic [TW-1:0]  reqType,
  input  logic [LW-1:0]  reqLen,
  input  logic           secTick,
  input  logic [NT*QW-1:0] baseFlat,
  input  logic [NT*QW-1:0] limFlat,
  input  logic [NT*PW-1:0] pctFlat,
  output logic           typeOk,
  output logic [NT*QW-1:0] orbitQFlat,
  output logic [NT*QW-1:0] secQFlat
);
  localparam int POOLW = QW + TW;
  localparam int TOTW  = POOLW + 1;
  localparam int MULW  = POOLW + PW;

  logic [QW-1:0]    orbitQ   [NT];
  logic [QW-1:0]    secQ     [NT];
  logic [QW-1:0]    secAvail [NT];
  logic [POOLW-1:0] poolSum, pool;

  function automatic logic [QW-1:0] takeBytes(input logic [QW-1:0] have,
                                              input logic [LW-1:0] len);
    logic [QW-1:0] lenX;
    lenX = QW'(len);
    return (have > lenX) ? have - lenX : '0;
  endfunction

  always_comb begin
    poolSum = '0;
    for (int i = 0; i < NT; i++) poolSum += POOLW'(orbitQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) pool <= '0;
    else if (strobe.capturePool) pool <= poolSum;
  end

  assign typeOk = (orbitQ[reqType] != '0) && (secAvail[reqType] != '0);

  for (genvar i = 0; i < NT; i++) begin : g_type
    logic [QW-1:0]   baseI, limI, reallocI;
    logic [PW-1:0]   pctI;
    logic [MULW-1:0] prod;
    logic [TOTW-1:0] total;
    logic            hit;

    assign baseI = baseFlat[i*QW +: QW];
    assign limI  = limFlat[i*QW +: QW];
    assign pctI  = pctFlat[i*PW +: PW];
    assign secAvail[i] = secTick ? limI : secQ[i];
    assign prod  = MULW'(pool) * MULW'(pctI);
    assign total = TOTW'(baseI) + TOTW'(prod >> PW);
    assign reallocI = (total > TOTW'({QW{1'b1}})) ? '1 : total[QW-1:0];
    assign hit = strobe.takeGrant && (reqType == TW'(i));

    always_ff @(posedge clk) begin
      if (!rstN || strobe.loadBase) begin
        orbitQ[i] <= baseI;
        secQ[i]   <= limI;
      end else begin
        if (strobe.loadRealloc) orbitQ[i] <= reallocI;
        else if (hit)           orbitQ[i] <= takeBytes(orbitQ[i], reqLen);
        secQ[i] <= hit ? takeBytes(secAvail[i], reqLen) : secAvail[i];
      end
    end

    assign orbitQFlat[i*QW +: QW] = orbitQ[i];
    assign secQFlat[i*QW +: QW]   = secQ[i];
  end
endmodule

// File: rtl/quota_throttle.sv
module quota_throttle
  import qthr_pkg::*;
#(
  parameter int NT = 4,
  parameter int QW = 16,
  parameter int LW = 12,
  parameter int PW = 8,
  localparam int TW = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [TW-1:0]    reqType,
  input  logic [LW-1:0]    reqLen,
  input  logic             secTick,
  input  logic             orbitEnd,
  input  logic             quotaReset,
  input  logic [NT*QW-1:0] baseAlloc,
  input  logic [NT*QW-1:0] secLimit,
  input  logic [NT*PW-1:0] sharePct,
  output logic             grant,
  output logic             blocked,
  output logic             busy
);
  qthr_strobe_t    strobe;
  logic            typeOk;
  logic [NT*QW-1:0] orbitQFlat, secQFlat;

  qthr_ctl ctl_i (
    .clk, .rstN, .reqValid, .typeOk, .orbitEnd, .quotaReset,
    .strobe, .grant, .blocked, .busy
  );

  qthr_dp #(.NT(NT), .QW(QW), .LW(LW), .PW(PW)) dp_i (
    .clk, .rstN, .strobe, .reqType, .reqLen, .secTick,
    .baseFlat(baseAlloc), .limFlat(secLimit), .pctFlat(sharePct),
    .typeOk, .orbitQFlat, .secQFlat
  );
endmodule

// File: rtl/qthr_chk.sv
module qthr_chk #(
  parameter int NT = 4,
  parameter int QW = 16,
  parameter int TW = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [TW-1:0]    reqType,
  input logic             secTick,
  input logic             orbitEnd,
  input logic             quotaReset,
  input logic             grant,
  input logic             blocked,
  input logic             busy,
  input logic [NT*QW-1:0] orbitQFlat,
  input logic [NT*QW-1:0] secQFlat
);
  // R2
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grant || blocked) == reqValid) && !(grant && blocked));

  // R8
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy || orbitEnd) |-> !grant);

  // R4
  orbit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && orbitQFlat[reqType*QW +: QW] == '0) |-> !grant);

  // R5
  sec_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !secTick && secQFlat[reqType*QW +: QW] == '0) |-> !grant);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN || quotaReset)
    $rose(busy) |=> busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN || quotaReset)
    (busy && $past(busy)) |=> !busy);

  // R7
  reset_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    quotaReset |=> !busy);
endmodule

bind quota_throttle qthr_chk #(.NT(NT), .QW(QW), .TW(TW)) chk_i (
  .clk, .rstN, .reqValid, .reqType, .secTick, .orbitEnd, .quotaReset,
  .grant, .blocked, .busy, .orbitQFlat, .secQFlat
);

// File: tb/quota_throttle_tb_top.sv
`timescale 1ns/1ps
module quota_throttle_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqType = '0;
  logic [11:0] reqLen = '0;
  logic        secTick = 1'b0, orbitEnd = 1'b0, quotaReset = 1'b0;
  logic [63:0] baseAlloc, secLimit;
  logic [31:0] sharePct;
  logic        grant, blocked, busy;

  always #2.5 clk = ~clk;

  quota_throttle dut_i (.*);

  int nChecks = 0, nBad = 0;
  int base[4], lim[4], pct[4], oq[4], sq[4];
  int st = 0;
  longint pool = 0;
  bit finished = 0;

  task automatic applyCfg();
    for (int i = 0; i < 4; i++) begin
      baseAlloc[i*16 +: 16] = base[i][15:0];
      secLimit[i*16 +: 16]  = lim[i][15:0];
      sharePct[i*8 +: 8]    = pct[i][7:0];
    end
  endtask

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    nChecks++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s got=%0b exp=%0b", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit v, input int t, input int len, input bit tk,
                      input bit oe, input bit qr, input string tag);
    bit expG;
    int avail;
    @(negedge clk);
    reqValid = v; reqType = t[1:0]; reqLen = len[11:0];
    secTick = tk; orbitEnd = oe; quotaReset = qr;
    #1;
    avail = tk ? lim[t] : sq[t];
    expG = v && st == 0 && !oe && !qr && oq[t] != 0 && avail != 0;
    chk(grant, expG, tag, "grant");
    chk(blocked, v && !expG, tag, "blocked");
    chk(busy, st != 0, tag, "busy");
    @(posedge clk);
    if (qr) begin
      for (int i = 0; i < 4; i++) begin oq[i] = base[i]; sq[i] = lim[i]; end
      st = 0;
    end else begin
      for (int i = 0; i < 4; i++) if (tk) sq[i] = lim[i];
      if (expG) begin
        oq[t] = (oq[t] > len) ? oq[t] - len : 0;
        sq[t] = (sq[t] > len) ? sq[t] - len : 0;
      end
      case (st)
        0: if (oe) st = 1;
        1: begin
          pool = 0;
          for (int i = 0; i < 4; i++) pool += oq[i];
          st = 2;
        end
        default: begin
          for (int i = 0; i < 4; i++) begin
            longint nv;
            nv = base[i] + ((pool * pct[i]) >> 8);
            oq[i] = (nv > 65535) ? 65535 : int'(nv);
          end
          st = 0;
        end
      endcase
    end
  endtask

  // Empty one type in big chunks, then probe the last bytes singly.
  task automatic drain(input int t, input string tag);
    int guard;
    guard = 0;
    while (oq[t] > 2 && guard < 100) begin
      step(1, t, (oq[t] - 2 > 4095) ? 4095 : oq[t] - 2, 1, 0, 0, tag);
      guard++;
    end
    step(1, t, 1, 1, 0, 0, tag);
    step(1, t, 1, 1, 0, 0, tag);
    step(1, t, 1, 1, 0, 0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    base = '{100, 200, 300, 50};
    lim  = '{4000, 4000, 4000, 4000};
    pct  = '{64, 128, 32, 255};
    applyCfg();
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin oq[i] = base[i]; sq[i] = lim[i]; end
    #1;
    chk(busy, 1'b0, "R1", "busy after reset");
    chk(grant, 1'b0, "R1", "grant after reset");
    for (int t = 0; t < 4; t++) drain(t, "R1");
    for (int t = 0; t < 4; t++) step(1, t, 1, 1, 0, 0, "R4");

    // R7: reload with a request in the same cycle
    step(1, 0, 1, 0, 0, 1, "R7");
    step(1, 0, 30, 0, 0, 0, "R2");
    step(1, 2, 400, 0, 0, 0, "R3");
    step(1, 2, 1, 0, 0, 0, "R3");
    step(1, 3, 10, 0, 0, 0, "R4");
    // R8: pulse with request, extra pulse while busy
    step(1, 1, 1, 0, 1, 0, "R8");
    step(1, 1, 1, 0, 1, 0, "R8");
    step(1, 1, 1, 0, 0, 0, "R8");
    for (int t = 0; t < 4; t++) drain(t, "R9");

    // R9 saturation
    base[0] = 65500; applyCfg();
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    drain(0, "R9");
    base[0] = 100; applyCfg();

    // R5 / R6 per-second budget
    lim[1] = 20; applyCfg();
    step(0, 0, 0, 0, 0, 1, "R7");
    for (int k = 0; k < 4; k++) step(1, 1, 7, 0, 0, 0, "R5");
    step(1, 1, 5, 1, 0, 0, "R6");
    step(1, 1, 20, 0, 0, 0, "R5");
    lim[1] = 0; applyCfg();
    step(1, 1, 1, 1, 0, 0, "R6");
    lim[1] = 60; applyCfg();
    step(1, 1, 1, 1, 0, 0, "R6");

    // R2 mixed traffic sweep
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      bit v, tk, oe, qr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v  = lfsr[2:0] != 3'd0;
      tk = lfsr[7:3] == 5'd0;
      oe = lfsr[14:8] == 7'd5;
      qr = (lfsr[15:7] == 9'd3);
      step(v, int'(lfsr[9:8]), int'(lfsr[13:8]) + 1, tk, oe, qr, "R2");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule